// File: doc/BRIEF.md
# External Interrupt Port Source Multiplexer

This block chooses, for each of sixteen external-interrupt lines, which general-purpose port supplies that line's pin. Line x can be fed by pin x of port A, B, C, D or E, and a small set of lines (0, 1, 9 and 10) can also be fed by pin x of port H. The choice for each line is a 4-bit source code. Software writes these codes through a simple word-wide register bus. Four codes are packed into the low half of each 32-bit selector register, and there are four such registers at consecutive word addresses.

The selected line signals go straight to a downstream edge detector, which is not part of this block. The path from the pins to the lines is purely combinational. The only clocked state is the set of selector codes. A code that names no port, or names port H on a line that has no port-H pin, forces that line low. This gives the edge detector a defined, quiet input.

Top module: `eim_src_mux`

## Requirements
- R1: While reset is asserted, and after it is released with no write, every selector code is 0000, every line follows port A, and every selector register reads 0.
- R2: Selector register k (k = 0..3) sits at byte offset 0x08 + 4k. The code for line 4k+n occupies bits 4n+3:4n of that register.
- R3: Codes 0000, 0001, 0010, 0011 and 0100 route pin x of port A, B, C, D and E respectively to line x.
- R4: Code 0101 routes pin x of port H to line x on lines 0, 1, 9 and 10.
- R5: Code 0101 on any line other than 0, 1, 9 and 10 drives that line low.
- R6: Codes 0110 through 1111 drive the line low.
- R7: A write to a selector register changes the codes on the next rising clock edge. A read of a selector register returns the stored codes in bits 15:0, and bits 31:16 always read 0 whatever was written there.
- R8: A write to any address other than the four selector offsets (including offsets that are not word aligned) changes no code. A read of such an address returns 0.
- R9: A change on a port pin reaches the selected line within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write strobe for the register bus |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| port_a | input | 16 | Pins of port A |
| port_b | input | 16 | Pins of port B |
| port_c | input | 16 | Pins of port C |
| port_d | input | 16 | Pins of port D |
| port_e | input | 16 | Pins of port E |
| port_h | input | 16 | Pins of port H |
| line_o | output | 16 | Selected source for each interrupt line |

## Verification
The bound checker checks several rules on every cycle. A line holding a reserved code, or a port-H code on a line without port H, is low. Port A, port E and the valid port-H routes follow their pins. The upper half of the read data is zero. A write to a selector offset lands in the stored codes one edge later, and a write elsewhere leaves all codes unchanged. Other rules can only be shown by the bench's scenarios: the field placement of each line inside its register, the routing from ports B to D, the reset state, and the same-cycle pin propagation. The bench sweeps every code on every line, uses random pins and random register contents, writes to unaligned and unmapped addresses, and asserts reset again in the middle of a run.

// File: rtl/eim_pkg.sv
package eim_pkg;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_PA = 4'd0,
        SRC_PB = 4'd1,
        SRC_PC = 4'd2,
        SRC_PD = 4'd3,
        SRC_PE = 4'd4,
        SRC_PH = 4'd5
    } src_code_e;
endpackage

// File: rtl/eim_sel_regs.sv
module eim_sel_regs #(
    parameter int                N_REGS     = 4,
    parameter int                FIELD_BITS = 16,
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h08
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wen,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic [N_REGS*FIELD_BITS-1:0] sel_flat
);
    localparam int                IDX_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [ADDR_W-3:0] REG_CNT = N_REGS[ADDR_W-3:0];

    logic [N_REGS-1:0][FIELD_BITS-1:0] regs_q;
    logic [ADDR_W-1:0]                 off;
    logic                              hit;
    logic [IDX_W-1:0]                  idx;

    assign off = reg_addr - BASE_ADDR;
    assign hit = (reg_addr >= BASE_ADDR) && (off[1:0] == 2'b00) && (off[ADDR_W-1:2] < REG_CNT);
    assign idx = off[IDX_W+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (reg_wen && hit) begin
            regs_q[idx] <= reg_wdata[FIELD_BITS-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            reg_rdata[FIELD_BITS-1:0] = regs_q[idx];
        end
    end

    assign sel_flat = regs_q;
endmodule

// File: rtl/eim_line_mux.sv
module eim_line_mux
    import eim_pkg::*;
#(
    parameter bit H_OK = 1'b0
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             pin_c,
    input  logic             pin_d,
    input  logic             pin_e,
    input  logic             pin_h,
    output logic             line
);
    always_comb begin
        unique case (sel)
            SRC_PA:  line = pin_a;
            SRC_PB:  line = pin_b;
            SRC_PC:  line = pin_c;
            SRC_PD:  line = pin_d;
            SRC_PE:  line = pin_e;
            SRC_PH:  line = H_OK ? pin_h : 1'b0;
            default: line = 1'b0;
        endcase
    end
endmodule

// File: rtl/eim_src_mux.sv
module eim_src_mux
    import eim_pkg::*;
#(
    parameter int                 N_LINES     = 16,
    parameter int                 DATA_W      = 32,
    parameter int                 ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR   = 8'h08,
    parameter logic [N_LINES-1:0] H_LINE_MASK = 16'h0603
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wen,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [N_LINES-1:0] port_a,
    input  logic [N_LINES-1:0] port_b,
    input  logic [N_LINES-1:0] port_c,
    input  logic [N_LINES-1:0] port_d,
    input  logic [N_LINES-1:0] port_e,
    input  logic [N_LINES-1:0] port_h,
    output logic [N_LINES-1:0] line_o
);
    localparam int FIELD_BITS = DATA_W / 2;
    localparam int PER_REG    = FIELD_BITS / SEL_W;
    localparam int N_REGS     = N_LINES / PER_REG;

    logic [N_LINES*SEL_W-1:0] sel_flat;

    eim_sel_regs #(
        .N_REGS    (N_REGS),
        .FIELD_BITS(FIELD_BITS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wen  (reg_wen),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sel_flat (sel_flat)
    );

    for (genvar li = 0; li < N_LINES; li++) begin : g_line
        eim_line_mux #(
            .H_OK(H_LINE_MASK[li])
        ) u_mux (
            .sel  (sel_flat[li*SEL_W +: SEL_W]),
            .pin_a(port_a[li]),
            .pin_b(port_b[li]),
            .pin_c(port_c[li]),
            .pin_d(port_d[li]),
            .pin_e(port_e[li]),
            .pin_h(port_h[li]),
            .line (line_o[li])
        );
    end
endmodule

// File: rtl/eim_src_mux_chk.sv
module eim_src_mux_chk #(
    parameter int                 N_LINES     = 16,
    parameter int                 SEL_W       = 4,
    parameter int                 DATA_W      = 32,
    parameter int                 ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR   = 8'h08,
    parameter logic [N_LINES-1:0] H_LINE_MASK = 16'h0603
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wen,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic [DATA_W-1:0]        reg_rdata,
    input logic [N_LINES-1:0]       port_a,
    input logic [N_LINES-1:0]       port_e,
    input logic [N_LINES-1:0]       port_h,
    input logic [N_LINES-1:0]       line_o,
    input logic [N_LINES*SEL_W-1:0] sel_flat
);
    localparam int FIELD_BITS = DATA_W / 2;
    localparam int N_REGS     = (N_LINES * SEL_W) / FIELD_BITS;

    logic in_map;
    always_comb begin
        in_map = 1'b0;
        for (int k = 0; k < N_REGS; k++) begin
            if (int'(reg_addr) == int'(BASE_ADDR) + 4 * k) in_map = 1'b1;
        end
    end

    p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:FIELD_BITS] == '0);

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && !in_map) |=> $stable(sel_flat));

    for (genvar k = 0; k < N_REGS; k++) begin : g_reg
        p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wen && int'(reg_addr) == int'(BASE_ADDR) + 4 * k)
            |=> sel_flat[k*FIELD_BITS +: FIELD_BITS] == $past(reg_wdata[FIELD_BITS-1:0]));
    end

    for (genvar li = 0; li < N_LINES; li++) begin : g_ln
        p_rsv_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[li*SEL_W +: SEL_W] > 4'd5) |-> !line_o[li]);

        p_port_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[li*SEL_W +: SEL_W] == 4'd0) |-> line_o[li] == port_a[li]);

        p_port_e_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[li*SEL_W +: SEL_W] == 4'd4) |-> line_o[li] == port_e[li]);

        if (H_LINE_MASK[li]) begin : g_h
            p_h_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_flat[li*SEL_W +: SEL_W] == 4'd5) |-> line_o[li] == port_h[li]);
        end else begin : g_noh
            p_h_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_flat[li*SEL_W +: SEL_W] == 4'd5) |-> !line_o[li]);
        end
    end
endmodule

bind eim_src_mux eim_src_mux_chk #(
    .N_LINES    (N_LINES),
    .SEL_W      (eim_pkg::SEL_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .H_LINE_MASK(H_LINE_MASK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wen  (reg_wen),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .port_a   (port_a),
    .port_e   (port_e),
    .port_h   (port_h),
    .line_o   (line_o),
    .sel_flat (sel_flat)
);

// File: tb/eim_src_mux_tb_top.sv
module eim_src_mux_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] port_a = '0, port_b = '0, port_c = '0, port_d = '0, port_e = '0, port_h = '0;
    logic [15:0] line_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit rand_pins = 1'b0;
    bit done = 1'b0;
    int sel_m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    eim_src_mux dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d),
        .port_e(port_e), .port_h(port_h), .line_o(line_o)
    );

    function automatic bit is_sel_addr(input int a);
        return (a >= 8) && (a <= 20) && (a % 4 == 0);
    endfunction

    function automatic bit h_line(input int i);
        return (i == 0) || (i == 1) || (i == 9) || (i == 10);
    endfunction

    function automatic logic exp_line(input int i);
        case (sel_m[i])
            0: return port_a[i];
            1: return port_b[i];
            2: return port_c[i];
            3: return port_d[i];
            4: return port_e[i];
            5: return h_line(i) ? port_h[i] : 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v = '0;
        int a = int'(reg_addr);
        if (is_sel_addr(a)) begin
            for (int n = 0; n < 4; n++) v[4*n +: 4] = 4'(sel_m[(a - 8) / 4 * 4 + n]);
        end
        return v;
    endfunction

    // Behavioural model of the stored codes
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) sel_m[i] = 0;
        end else if (reg_wen && is_sel_addr(int'(reg_addr))) begin
            for (int n = 0; n < 4; n++)
                sel_m[(int'(reg_addr) - 8) / 4 * 4 + n] = int'(reg_wdata[4*n +: 4]);
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            logic [15:0] e;
            logic [31:0] er;
            string tag;
            for (int i = 0; i < 16; i++) e[i] = exp_line(i);
            n_cmp++;
            if (line_o !== e) begin
                tag = "R3";
                for (int i = 15; i >= 0; i--) begin
                    if (line_o[i] !== e[i]) begin
                        if (sel_m[i] > 5) tag = "R6";
                        else if (sel_m[i] == 5) tag = h_line(i) ? "R4" : "R5";
                        else tag = "R3";
                    end
                end
                n_bad++;
                $display("FAIL %s line_o actual=%h expected=%h", tag, line_o, e);
            end
            er = exp_rdata();
            n_cmp++;
            if (reg_rdata !== er) begin
                n_bad++;
                $display("FAIL %s reg_rdata @%h actual=%h expected=%h",
                         is_sel_addr(int'(reg_addr)) ? "R7" : "R8", reg_addr, reg_rdata, er);
            end
        end
    end

    always @(posedge clk) begin
        if (rand_pins) begin
            #1;
            port_a = 16'($urandom); port_b = 16'($urandom); port_c = 16'($urandom);
            port_d = 16'($urandom); port_e = 16'($urandom); port_h = 16'($urandom);
            if (!reg_wen) reg_addr = 8'($urandom_range(0, 31));
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wen = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        port_a = 16'hA5C3; port_b = 16'hFFFF;
        idle(2);
        #1 check("R1 line_o in reset", 32'(line_o), 32'hA5C3);
        @(posedge clk); #2 rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); reg_addr = 8'(8 + 4 * k); #1;
            check("R1 reg reads zero", reg_rdata, 32'h0);
        end

        // R2: field placement, line 8 -> port B via offset 0x10 bits 3:0
        port_a = 16'h0000; port_b = 16'hFFFF;
        wr(8'h10, 32'h0000_0001);
        @(negedge clk);
        check("R2 line 8 from port B", 32'(line_o), 32'h0000_0100);
        wr(8'h14, 32'h0000_1000);  // line 15 -> port B
        @(negedge clk);
        check("R2 line 15 from port B", 32'(line_o), 32'h0000_8100);

        // R9: same-cycle propagation with no clock edge
        @(negedge clk); #1 port_b = 16'h0000; #1;
        check("R9 pin change propagates", 32'(line_o), 32'h0);
        port_b = 16'hFFFF;

        // R7: upper half ignored and reads zero
        wr(8'h08, 32'hDEAD_4321);
        @(negedge clk); reg_addr = 8'h08; #1;
        check("R7 readback", reg_rdata, 32'h0000_4321);

        // R5: port H code on a line without port H is low
        port_h = 16'hFFFF;
        for (int k = 0; k < 4; k++) wr(8'(8 + 4 * k), 32'h0000_5555);
        @(negedge clk);
        check("R5/R4 port H only on lines 0,1,9,10", 32'(line_o), 32'h0000_0603);

        // R8: unmapped and unaligned writes are ignored
        wr(8'h09, 32'h0000_0000);
        wr(8'h04, 32'h0000_0000);
        wr(8'h18, 32'h0000_0000);
        wr(8'h00, 32'h0000_0000);
        @(negedge clk); reg_addr = 8'h0C; #1;
        check("R8 codes unchanged", reg_rdata, 32'h0000_5555);
        reg_addr = 8'h18; #1;
        check("R8 unmapped read zero", reg_rdata, 32'h0);

        // Sweep every code on every line with random pins (R3 R4 R5 R6)
        rand_pins = 1'b1;
        for (int c = 0; c < 16; c++) begin
            logic [15:0] f;
            f = {4'(c), 4'(c), 4'(c), 4'(c)};
            for (int k = 0; k < 4; k++) wr(8'(8 + 4 * k), {16'($urandom), f});
            idle(8);
        end

        // Random contents and random writes including stray addresses (R7 R8)
        for (int t = 0; t < 300; t++) begin
            wr(8'($urandom_range(0, 31)), $urandom);
            idle(2);
        end

        // Reset again mid-run (R1)
        @(posedge clk); #2 rst_n = 1'b0;
        idle(3);
        @(posedge clk); #2 rst_n = 1'b1;
        idle(20);
        rand_pins = 1'b0;
        idle(2);
        finish_run();
    end
endmodule